// File: doc/BRIEF.md
# Multi-Channel Compare Timer with PWM

This block holds several independent 16-bit up-counting channels behind a simple synchronous register port. Each channel has a period compare, a duty compare, a counter that software can load, and a control word. The control word picks which pulses the channel counts (every clock, a slow real-time tick, or an external tick) and a power-of-four prescaler. It also drives a PWM pin whose polarity can be chosen. A channel runs only while its enable bit is set and its stop bit is clear.

Four global registers hold enable, stop, match flags and interrupt masks. Each one can be written as a whole at its base address. Each also has a write-one-to-set alias and a write-one-to-clear alias, so single bits change without a read-modify-write. Every channel raises a period-match flag and a duty-match flag. The flags that are not masked are ORed into one registered interrupt line. The real-time and external tick inputs are single-cycle pulses that are already synchronous to the block clock.

Top module: `tmr_unit`

## Requirements
- R1: After reset: enable register 0, every channel's stop bit 1, every implemented mask bit 1, flags 0, both compare registers of every channel 0xFFFF, counters 0, control 0, and the irq and PWM pins low.
- R2: A write to a global register's base address replaces it. A write to its set alias ORs in the 1 bits and a write to its clear alias removes the 1 bits; 0 bits are untouched. Addresses: enable 0x10/0x14/0x18, stop 0x1C/0x2C/0x3C, flag 0x20/0x24/0x28, mask 0x30/0x34/0x38 (base/set/clear).
- R3: A channel's counter changes only on a prescaled tick taken while enable bit x is 1 and stop bit x is 0, or on a direct write. Otherwise it holds.
- R4: Control bits [5:3] = s divide the selected source by 4^s for s = 0..5; values 6 and 7 divide by 1024.
- R5: Control bit 0 counts every clock, bit 1 counts rtc_tick pulses and bit 2 counts ext_tick pulses. Selected sources are ORed; with none selected the channel does not count.
- R6: On a prescaled tick with the counter equal to the period compare (channel offset +0x0), flag bit x is set and the counter goes to 0. Otherwise the counter increments.
- R7: On a prescaled tick with the counter equal to the duty compare (offset +0x4), flag bit x+16 is set. Mask bits use the same positions.
- R8: irq is registered: it is 1 one cycle after any flag bit is 1 with its mask bit 0, and 0 one cycle after no such bit exists.
- R9: A flag stays set until it is cleared. A match in the same cycle as a clear leaves the flag set.
- R10: A write to the counter (offset +0x8) loads it on that edge and takes precedence over a tick in the same cycle.
- R11: The PWM pin is registered. With control bit 7 set it is 1 while counter < duty compare, inverted when control bit 8 is set. With bit 7 clear it sits at its inactive level, which is the value of bit 8.
- R12: A control write that changes the prescaler field restarts the divider: the first tick comes a full divide period of source pulses after that write.
- R13: bus_rdata is loaded on the edge where bus_rd is 1 and holds otherwise. Channel x's registers sit at 0x40 + 0x10·x + {0x0 period, 0x4 duty, 0x8 counter, 0xC control}. Set and clear aliases read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_tick | input | 1 | Slow tick pulse, one clock wide |
| ext_tick | input | 1 | External tick pulse, one clock wide |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered combined interrupt |
| pwm_out | output | NUM_CH | Registered PWM pins, one per channel |

## Verification
A divider that keeps its residue across a prescaler change shows up as a counter that is already one ahead when it is read back. This appears within one divide period. A wrong compare or wrap decision shows in the flag register and on irq one cycle after the match. A wrong gate shows as a counter that moves while its channel is stopped, and this is visible at the next read. A lost flag under a simultaneous clear, or a counter load that loses to a tick, is visible at the read that follows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 16;
  localparam int PRE_W = 10;

  // control word fields as held by a channel
  typedef struct packed {
    logic       pwm_low;
    logic       pwm_en;
    logic [2:0] div_sel;
    logic [2:0] src;
  } ch_ctrl_t;

  // global register byte addresses
  localparam int A_EN       = 'h10;
  localparam int A_EN_SET   = 'h14;
  localparam int A_EN_CLR   = 'h18;
  localparam int A_STOP     = 'h1C;
  localparam int A_STOP_SET = 'h2C;
  localparam int A_STOP_CLR = 'h3C;
  localparam int A_FLAG     = 'h20;
  localparam int A_FLAG_SET = 'h24;
  localparam int A_FLAG_CLR = 'h28;
  localparam int A_MASK     = 'h30;
  localparam int A_MASK_SET = 'h34;
  localparam int A_MASK_CLR = 'h38;
  localparam int CH_BASE    = 'h40;
  localparam int CH_STRIDE  = 'h10;

  // terminal divider value for a prescaler code: 4^code - 1, clamped at 1024
  function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] sel);
    int s;
    s = (sel > 3'd5) ? 5 : int'(sel);
    return PRE_W'((32'd1 << (2 * s)) - 32'd1);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = tmr_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart)  pre_q <= '0;
    else if (step) begin
      if (pre_q == limit) pre_q <= '0;
      else                pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = step && !restart && (pre_q == limit);

  // R4: the divider never runs past the selected terminal value
  a_r4_within_limit: assert property (@(posedge clk) disable iff (rst)
    pre_q <= limit);
  // R12: a restart leaves the divider at zero
  a_r12_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pre_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW    = tmr_pkg::CNT_W,
  parameter int PRE_W = tmr_pkg::PRE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          rtc_tick,
  input  logic          ext_tick,
  input  logic [CW-1:0] wdata,
  input  ch_ctrl_t      ctrl_wdata,
  input  logic          we_full,
  input  logic          we_half,
  input  logic          we_cnt,
  input  logic          we_ctrl,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] full_q,
  output logic [CW-1:0] half_q,
  output ch_ctrl_t      ctrl_q,
  output logic          full_hit,
  output logic          half_hit,
  output logic          pwm_q
);
  logic src_pulse, step, restart, tick;

  assign src_pulse = ctrl_q.src[0] | (ctrl_q.src[1] & rtc_tick) | (ctrl_q.src[2] & ext_tick);
  assign step      = run & src_pulse;
  assign restart   = we_ctrl && (ctrl_wdata.div_sel != ctrl_q.div_sel);

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .step    (step),
    .limit   (div_limit(ctrl_q.div_sel)),
    .tick    (tick)
  );

  assign full_hit = tick && (cnt_q == full_q);
  assign half_hit = tick && (cnt_q == half_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '1;
      half_q <= '1;
      ctrl_q <= '0;
    end else begin
      if (we_full) full_q <= wdata;
      if (we_half) half_q <= wdata;
      if (we_ctrl) ctrl_q <= ctrl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (we_cnt)   cnt_q <= wdata;
    else if (tick)     cnt_q <= full_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                pwm_q <= 1'b0;
    else if (ctrl_q.pwm_en) pwm_q <= (cnt_q < half_q) ^ ctrl_q.pwm_low;
    else                    pwm_q <= ctrl_q.pwm_low;
  end

  // R3: no run and no load means the counter holds
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!run && !we_cnt) |=> $stable(cnt_q));
  // R6: a period match wraps the counter to zero
  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (full_hit && !we_cnt) |=> (cnt_q == '0));
  // R10: a direct load wins over any tick
  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    we_cnt |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rtc_tick,
  input  logic              ext_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam logic [31:0] CH_BITS   = 32'((64'd1 << NUM_CH) - 64'd1);
  localparam logic [31:0] FLAG_BITS = CH_BITS | (CH_BITS << 16);

  logic [31:0] en_q, stop_q, flag_q, mask_q, hit_vec;
  logic [31:0] rd_mux;
  logic        irq_q;

  logic [CNT_W-1:0] cnt_a  [NUM_CH];
  logic [CNT_W-1:0] full_a [NUM_CH];
  logic [CNT_W-1:0] half_a [NUM_CH];
  ch_ctrl_t         ctrl_a [NUM_CH];
  logic [NUM_CH-1:0] full_hit, half_hit, we_full, we_half, we_cnt, we_ctrl;
  ch_ctrl_t         ctrl_wd;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  function automatic logic [31:0] upd(input logic [31:0] cur, input logic [31:0] wd,
                                      input logic b, input logic s, input logic c);
    if (b) return wd;
    if (s) return cur | wd;
    if (c) return cur & ~wd;
    return cur;
  endfunction

  assign ctrl_wd = '{pwm_low: bus_wdata[8], pwm_en: bus_wdata[7],
                     div_sel: bus_wdata[5:3], src: bus_wdata[2:0]};

  // per-channel write decode
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      we_full[i] = bus_wr && hit_addr(bus_addr, CH_BASE + CH_STRIDE * i + 'h0);
      we_half[i] = bus_wr && hit_addr(bus_addr, CH_BASE + CH_STRIDE * i + 'h4);
      we_cnt[i]  = bus_wr && hit_addr(bus_addr, CH_BASE + CH_STRIDE * i + 'h8);
      we_ctrl[i] = bus_wr && hit_addr(bus_addr, CH_BASE + CH_STRIDE * i + 'hC);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel #(.CW(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .run        (en_q[g] & ~stop_q[g]),
      .rtc_tick   (rtc_tick),
      .ext_tick   (ext_tick),
      .wdata      (bus_wdata[CNT_W-1:0]),
      .ctrl_wdata (ctrl_wd),
      .we_full    (we_full[g]),
      .we_half    (we_half[g]),
      .we_cnt     (we_cnt[g]),
      .we_ctrl    (we_ctrl[g]),
      .cnt_q      (cnt_a[g]),
      .full_q     (full_a[g]),
      .half_q     (half_a[g]),
      .ctrl_q     (ctrl_a[g]),
      .full_hit   (full_hit[g]),
      .half_hit   (half_hit[g]),
      .pwm_q      (pwm_out[g])
    );
  end

  always_comb begin
    hit_vec = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      hit_vec[i]      = full_hit[i];
      hit_vec[16 + i] = half_hit[i];
    end
  end

  // global registers with set/clear aliases; matches are ORed in last
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      stop_q <= CH_BITS;
      flag_q <= '0;
      mask_q <= FLAG_BITS;
    end else begin
      en_q   <= CH_BITS & upd(en_q, bus_wdata, bus_wr && hit_addr(bus_addr, A_EN),
                   bus_wr && hit_addr(bus_addr, A_EN_SET), bus_wr && hit_addr(bus_addr, A_EN_CLR));
      stop_q <= CH_BITS & upd(stop_q, bus_wdata, bus_wr && hit_addr(bus_addr, A_STOP),
                   bus_wr && hit_addr(bus_addr, A_STOP_SET), bus_wr && hit_addr(bus_addr, A_STOP_CLR));
      mask_q <= FLAG_BITS & upd(mask_q, bus_wdata, bus_wr && hit_addr(bus_addr, A_MASK),
                   bus_wr && hit_addr(bus_addr, A_MASK_SET), bus_wr && hit_addr(bus_addr, A_MASK_CLR));
      flag_q <= (FLAG_BITS & upd(flag_q, bus_wdata, bus_wr && hit_addr(bus_addr, A_FLAG),
                   bus_wr && hit_addr(bus_addr, A_FLAG_SET), bus_wr && hit_addr(bus_addr, A_FLAG_CLR)))
                | hit_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_q & ~mask_q);
  end
  assign irq = irq_q;

  // read mux
  always_comb begin
    rd_mux = '0;
    if (hit_addr(bus_addr, A_EN))   rd_mux = en_q;
    if (hit_addr(bus_addr, A_STOP)) rd_mux = stop_q;
    if (hit_addr(bus_addr, A_FLAG)) rd_mux = flag_q;
    if (hit_addr(bus_addr, A_MASK)) rd_mux = mask_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_addr(bus_addr, CH_BASE + CH_STRIDE * i + 'h0)) rd_mux = 32'(full_a[i]);
      if (hit_addr(bus_addr, CH_BASE + CH_STRIDE * i + 'h4)) rd_mux = 32'(half_a[i]);
      if (hit_addr(bus_addr, CH_BASE + CH_STRIDE * i + 'h8)) rd_mux = 32'(cnt_a[i]);
      if (hit_addr(bus_addr, CH_BASE + CH_STRIDE * i + 'hC))
        rd_mux = {23'd0, ctrl_a[i].pwm_low, ctrl_a[i].pwm_en, 1'b0,
                  ctrl_a[i].div_sel, ctrl_a[i].src};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9: a match leaves its flag set on the following cycle, even under a clear
  a_r9_match_sticks: assert property (@(posedge clk) disable iff (rst)
    (|hit_vec) |=> ((flag_q & $past(hit_vec)) == $past(hit_vec)));
  // R8: with nothing pending and unmasked, irq drops next cycle
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ~mask_q) == '0) |=> !irq);
  // R2: a set-alias write leaves every written 1 bit set
  a_r2_set_alias: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_addr(bus_addr, A_EN_SET))
      |=> ((en_q & $past(bus_wdata & CH_BITS)) == $past(bus_wdata & CH_BITS)));
  // R13: read data only moves on a read strobe
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rtc_tick = 1'b0, ext_tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  logic [NCH-1:0] pwm_out;

  int applied = 0;
  int miscompares = 0;

  tmr_unit #(.NUM_CH(NCH), .ADDR_W(8)) uut (
    .clk(clk), .rst(rst), .rtc_tick(rtc_tick), .ext_tick(ext_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {div_sel, src, rtc on, ext on, idle cycles P, expected count}; P+1 source edges counted
  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    {3'd0, 3'd1, 1'b0, 1'b0, 16'd9,    16'd10},
    {3'd1, 3'd1, 1'b0, 1'b0, 16'd19,   16'd5},
    {3'd2, 3'd1, 1'b0, 1'b0, 16'd63,   16'd4},
    {3'd3, 3'd1, 1'b0, 1'b0, 16'd127,  16'd2},
    {3'd4, 3'd1, 1'b0, 1'b0, 16'd511,  16'd2},
    {3'd5, 3'd1, 1'b0, 1'b0, 16'd2047, 16'd2},
    {3'd0, 3'd2, 1'b1, 1'b0, 16'd6,    16'd7},
    {3'd0, 3'd2, 1'b0, 1'b1, 16'd6,    16'd0},
    {3'd0, 3'd4, 1'b0, 1'b1, 16'd4,    16'd5},
    {3'd1, 3'd4, 1'b0, 1'b1, 16'd6,    16'd1},
    {3'd0, 3'd0, 1'b1, 1'b1, 16'd9,    16'd0},
    {3'd7, 3'd1, 1'b0, 1'b0, 16'd1023, 16'd1},
    {3'd2, 3'd1, 1'b0, 1'b0, 16'd14,   16'd0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    applied++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, read through R13 addresses
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pwm", 32'(pwm_out), 0);
    rd(8'h10, v); chk("R1 enable", v, 32'h0);
    rd(8'h1C, v); chk("R1 stop", v, 32'hF);
    rd(8'h30, v); chk("R1 mask", v, 32'h000F000F);
    rd(8'h20, v); chk("R1 flag", v, 32'h0);
    rd(8'h40, v); chk("R1 full0", v, 32'hFFFF);
    rd(8'h64, v); chk("R1 half2 (R13 stride)", v, 32'hFFFF);
    rd(8'h48, v); chk("R1 cnt0", v, 32'h0);

    // R2 aliases on enable
    wr(8'h14, 32'h5); rd(8'h10, v); chk("R2 set alias", v, 32'h5);
    wr(8'h18, 32'h4); rd(8'h10, v); chk("R2 clear alias", v, 32'h1);
    rd(8'h14, v); chk("R13 alias reads zero", v, 32'h0);
    wr(8'h10, 32'h0); rd(8'h10, v); chk("R2 base write", v, 32'h0);

    // R4 R5 table on channel 0
    wr(8'h3C, 32'h1);
    for (int i = 0; i < NV; i++) begin
      logic [2:0] sel, src;
      sel = VEC[i][39:37]; src = VEC[i][36:34];
      wr(8'h18, 32'h1);
      wr(8'h48, 32'h0);
      wr(8'h4C, {23'd0, 3'b000, sel ^ 3'd1, src});
      wr(8'h4C, {23'd0, 3'b000, sel, src});
      wr(8'h14, 32'h1);
      rtc_tick = VEC[i][33]; ext_tick = VEC[i][32];
      repeat (int'(VEC[i][31:16])) @(negedge clk);
      wr(8'h18, 32'h1);
      rtc_tick = 1'b0; ext_tick = 1'b0;
      rd(8'h48, v);
      chk($sformatf("R4/R5 vector %0d", i), v, 32'(VEC[i][15:0]));
    end

    // R6 R7 R8 on channel 0: period 3, duty 1
    wr(8'h40, 32'd3); wr(8'h44, 32'd1); wr(8'h48, 32'd0);
    wr(8'h4C, 32'h081);
    rd(8'h4C, v); chk("R13 control readback", v, 32'h081);
    wr(8'h38, 32'h1);
    wr(8'h14, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 irq before match", 32'(irq), 0);
    @(negedge clk);
    chk("R8 irq registered lag", 32'(irq), 0);
    @(negedge clk);
    chk("R8 irq after full match", 32'(irq), 1);
    wr(8'h18, 32'h1);
    rd(8'h20, v); chk("R6/R7 flags", v, 32'h00010001);
    rd(8'h48, v); chk("R6 wrap count", v, 32'd2);

    // R11 PWM levels with a held counter
    chk("R11 pwm inactive cnt>=duty", 32'(pwm_out[0]), 0);
    wr(8'h48, 32'd0); @(negedge clk);
    chk("R11 pwm active cnt<duty", 32'(pwm_out[0]), 1);
    wr(8'h4C, 32'h181); @(negedge clk);
    chk("R11 pwm active low", 32'(pwm_out[0]), 0);
    wr(8'h4C, 32'h101); @(negedge clk);
    chk("R11 pwm off low polarity", 32'(pwm_out[0]), 1);
    wr(8'h4C, 32'h001); @(negedge clk);
    chk("R11 pwm off high polarity", 32'(pwm_out[0]), 0);

    // R9 clear, R2 flag aliases
    wr(8'h28, 32'h1);
    rd(8'h20, v); chk("R9 cleared flag", v, 32'h00010000);
    chk("R8 irq drops", 32'(irq), 0);
    wr(8'h24, 32'h00020000);
    rd(8'h20, v); chk("R2 flag set alias", v, 32'h00030000);
    wr(8'h20, 32'h0);
    rd(8'h20, v); chk("R2 flag base write", v, 32'h0);

    // R9 clear collides with match, R10 load while running
    wr(8'h40, 32'd0); wr(8'h48, 32'd0);
    wr(8'h14, 32'h1);
    wr(8'h28, 32'h1);
    rd(8'h20, v); chk("R9 match beats clear", v, 32'h1);
    wr(8'h48, 32'd5);
    rd(8'h48, v); chk("R10 load over tick", v, 32'd5);
    wr(8'h18, 32'h1);
    rd(8'h48, v); chk("R10 count after load", v, 32'd7);
    repeat (5) @(negedge clk);
    rd(8'h48, v); chk("R3 disabled holds", v, 32'd7);

    // R3 stop gating on channel 1
    wr(8'h5C, 32'h001); wr(8'h58, 32'd0);
    wr(8'h14, 32'h2);
    repeat (10) @(negedge clk);
    rd(8'h58, v); chk("R3 stopped channel", v, 32'd0);
    wr(8'h3C, 32'h2);
    repeat (5) @(negedge clk);
    wr(8'h2C, 32'h2);
    rd(8'h58, v); chk("R3 runs while unstopped", v, 32'd6);

    // R12 prescaler restart on channel 1
    wr(8'h18, 32'h2);
    wr(8'h5C, 32'h009); wr(8'h58, 32'd0);
    wr(8'h3C, 32'h2);
    wr(8'h14, 32'h2);
    repeat (2) @(negedge clk);
    wr(8'h5C, 32'h011);
    repeat (14) @(negedge clk);
    wr(8'h18, 32'h2);
    rd(8'h58, v); chk("R12 no early tick", v, 32'd0);
    wr(8'h14, 32'h2);
    wr(8'h18, 32'h2);
    rd(8'h58, v); chk("R12 tick after full period", v, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule